// File: doc/BRIEF.md
# Reliable Bit Aggregator

This block builds a device key from a sense-amplifier PUF array in the field. It runs in two phases. In the first, it takes a stored reliability bitmap in through a write port, one word per accepted beat, and writes it into an internal RAM. The bitmap marks which cells of the PUF array resolve consistently. It records only where those cells are and never what value they hold.

In the second phase, the block walks the PUF array from address zero, one word per cycle. It reads the matching bitmap word at the same address. It keeps only the PUF bits whose bitmap bit is set and packs them densely into a 512-bit key register. A word can contribute anywhere from zero to four bits. Within a word, bit 0 is considered first.

Collection stops when one of two things happens. The first is that the programmed number of bits has been gathered. The second is that the last address has been processed. The lowest 128 collected bits drive the key output. The block also reports a valid flag, a short flag and the number of bits gathered.

Top module: `reliable_bit_agg`

## Requirements
- R1: A pulse on `start_load` while idle enters the load phase. Each cycle with `ld_valid` high writes `ld_word` to the next bitmap address, starting at 0. Cycles with `ld_valid` low write nothing. `busy` stays high until the DEPTH-th word has been accepted and is low on the following cycle. No PUF read is issued during the load phase.
- R2: Only PUF bits whose bitmap bit is 1 are collected. A bitmap word of 0 contributes nothing, whatever the PUF word holds.
- R3: Collected bits are ordered by ascending address, and within a word from bit 0 up to bit 3. Collected bit k is stored at key-register bit k, and `key[127:0]` is key-register bits 127..0. Accepting `start_gen` clears the key register. The key does not change while the block is idle.
- R4: During generation, `puf_rd_en` is high with `puf_addr` counting up from 0 by one per cycle. `puf_word` is taken from the PUF array one cycle after the read that requested it.
- R5: Collection stops as soon as the count reaches the target. Further selected bits in that same word are discarded, and `bit_count` equals the target. Exactly one more read is issued after the word that reached the target, and its data is dropped. When the target-reaching word is the last address, no extra read is issued.
- R6: The target is sampled when `start_gen` is accepted. A value of 0 is treated as 1, and any value above 512 is treated as 512.
- R7: If the last address has been processed and the count is still below the target, the block stops, raises `short_flag`, and `bit_count` shows the number of bits collected. If the target is met exactly on the last address, `short_flag` stays low.
- R8: `key_valid` is high only while idle after a finished generation that collected at least 128 bits. It is cleared when `start_gen` or `start_load` is accepted.
- R9: `start_gen` and `start_load` are ignored while `busy` is high. When both arrive together while idle, the load phase wins.
- R10: While busy, `bit_count` never decreases and grows by at most 4 per cycle. It never exceeds 512.
- R11: After reset the block is idle. `bit_count`, `key`, `key_valid`, `short_flag` and `puf_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_load | input | 1 | Begin bitmap load phase (idle only) |
| ld_valid | input | 1 | Bitmap word present on `ld_word` |
| ld_word | input | 4 | Bitmap word, bit i marks PUF bit i of that address reliable |
| start_gen | input | 1 | Begin key collection (idle only) |
| target | input | 10 | Number of bits to collect, 1 to 512 after clamping |
| puf_rd_en | output | 1 | PUF array read request |
| puf_addr | output | 10 | PUF array word address |
| puf_word | input | 4 | PUF value word, one cycle after the request |
| busy | output | 1 | Load or generation in progress |
| bit_count | output | 10 | Bits collected so far |
| key | output | 128 | Lowest 128 bits of the key register |
| key_valid | output | 1 | Generation done with at least 128 bits |
| short_flag | output | 1 | Array exhausted before the target was reached |

## Verification
Two events can fall in the same cycle. The insertion that brings the count up to the target can coincide with the processing of the last array address. This is provoked with a bitmap whose total number of set bits equals the target, with the final set bits placed at the last address. The result is judged by requiring `short_flag` low and `bit_count` equal to the target.

The stopping insertion also always meets the arrival of the one read already in flight. The bench therefore counts the read strobes in each run and compares that count against the exact expected figure. It also checks that the key holds no bit taken from the word that arrived after the stop.

// File: rtl/rba_pkg.sv
package rba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_GEN   = 2'd2,
    ST_DRAIN = 2'd3
  } rba_state_e;
endpackage

// File: rtl/rba_bitmap_ram.sv
// Simple dual-port bitmap store: one write port, one registered read port.
module rba_bitmap_ram #(
  parameter int W     = 4,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rba_packer.sv
// Prefix-count packer: gives each selected bit its destination slot.
module rba_packer #(
  parameter int W  = 4,
  parameter int CW = 10
) (
  input  logic            valid,
  input  logic [W-1:0]    mask,
  input  logic [CW-1:0]   count,
  input  logic [CW-1:0]   target,
  output logic [W-1:0]    take,
  output logic [W*CW-1:0] pos,
  output logic [CW-1:0]   new_count,
  output logic            reach
);
  logic [CW:0] acc;

  always_comb begin
    acc  = {1'b0, count};
    take = '0;
    pos  = '0;
    for (int i = 0; i < W; i++) begin
      pos[i*CW +: CW] = acc[CW-1:0];
      take[i] = valid && mask[i] && (acc < {1'b0, target});
      if (mask[i]) acc = acc + 1'b1;
    end
    reach = valid && (acc >= {1'b0, target});
    if (!valid)     new_count = count;
    else if (reach) new_count = target;
    else            new_count = acc[CW-1:0];
  end
endmodule

// File: rtl/rba_keyreg.sv
// Key register: every bit position selects from the up-to-W insertions.
module rba_keyreg #(
  parameter int W  = 4,
  parameter int CW = 10,
  parameter int KW = 512,
  parameter int KO = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [W-1:0]    take,
  input  logic [W*CW-1:0] pos,
  input  logic [W-1:0]    val,
  output logic [KO-1:0]   key_out
);
  logic [KW-1:0] bits_q;
  logic [KW-1:0] hit_v;
  logic [KW-1:0] dat_v;

  for (genvar j = 0; j < KW; j++) begin : g_slot
    logic [W-1:0] m;
    for (genvar i = 0; i < W; i++) begin : g_src
      assign m[i] = take[i] && (pos[i*CW +: CW] == CW'(j));
    end
    assign hit_v[j] = |m;
    assign dat_v[j] = |(m & val);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) bits_q <= '0;
    else            bits_q <= (bits_q & ~hit_v) | (dat_v & hit_v);
  end

  assign key_out = bits_q[KO-1:0];
endmodule

// File: rtl/rba_ctrl.sv
// Phase sequencer: bitmap load, address walk, stop decision, status.
module rba_ctrl
  import rba_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int CW    = 10,
  parameter int KW    = 512,
  parameter int KO    = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_load,
  input  logic          ld_valid,
  input  logic          start_gen,
  input  logic [CW-1:0] target,
  input  logic          reach,
  input  logic [CW-1:0] new_count,
  output logic          busy,
  output logic          ram_we,
  output logic [AW-1:0] ld_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          s_vld,
  output logic          clr,
  output logic [CW-1:0] tgt,
  output logic [CW-1:0] count,
  output logic          short_flag,
  output logic          key_valid
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rba_state_e    state;
  logic [AW-1:0] ld_addr_q, rd_addr_q;
  logic [CW-1:0] tgt_q, cnt_q, tgt_clamp;
  logic          short_q, kv_q, s_vld_q, s_last_q;
  logic          acc_load, acc_gen, hit_end;

  assign acc_load = (state == ST_IDLE) && start_load;
  assign acc_gen  = (state == ST_IDLE) && start_gen && !start_load;
  assign hit_end  = s_vld_q && (reach || s_last_q);

  always_comb begin
    if (target == '0)           tgt_clamp = CW'(1);
    else if (target > CW'(KW))  tgt_clamp = CW'(KW);
    else                        tgt_clamp = target;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ld_addr_q <= '0;
      rd_addr_q <= '0;
      tgt_q     <= CW'(1);
      cnt_q     <= '0;
      short_q   <= 1'b0;
      kv_q      <= 1'b0;
      s_vld_q   <= 1'b0;
      s_last_q  <= 1'b0;
    end else begin
      s_vld_q  <= (state == ST_GEN) && !hit_end;
      s_last_q <= (state == ST_GEN) && (rd_addr_q == LAST);
      if (s_vld_q) cnt_q <= new_count;
      if (hit_end) begin
        short_q <= (new_count < tgt_q);
        kv_q    <= (new_count >= CW'(KO));
      end
      case (state)
        ST_IDLE: begin
          if (acc_load) begin
            state     <= ST_LOAD;
            ld_addr_q <= '0;
            kv_q      <= 1'b0;
            short_q   <= 1'b0;
          end else if (acc_gen) begin
            state     <= ST_GEN;
            rd_addr_q <= '0;
            cnt_q     <= '0;
            kv_q      <= 1'b0;
            short_q   <= 1'b0;
            tgt_q     <= tgt_clamp;
          end
        end
        ST_LOAD: begin
          if (ld_valid) begin
            ld_addr_q <= ld_addr_q + 1'b1;
            if (ld_addr_q == LAST) state <= ST_IDLE;
          end
        end
        ST_GEN: begin
          if (hit_end)                 state <= ST_IDLE;
          else if (rd_addr_q == LAST)  state <= ST_DRAIN;
          else                         rd_addr_q <= rd_addr_q + 1'b1;
        end
        default: begin
          if (hit_end) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign ram_we     = (state == ST_LOAD) && ld_valid;
  assign ld_addr    = ld_addr_q;
  assign rd_en      = (state == ST_GEN);
  assign rd_addr    = rd_addr_q;
  assign s_vld      = s_vld_q;
  assign clr        = acc_gen;
  assign tgt        = tgt_q;
  assign count      = cnt_q;
  assign short_flag = short_q;
  assign key_valid  = kv_q;
endmodule

// File: rtl/reliable_bit_agg.sv
module reliable_bit_agg #(
  parameter int WORD_W    = 4,
  parameter int DEPTH     = 1024,
  parameter int KEY_W     = 512,
  parameter int KEY_OUT_W = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(KEY_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_load,
  input  logic                 ld_valid,
  input  logic [WORD_W-1:0]    ld_word,
  input  logic                 start_gen,
  input  logic [CW-1:0]        target,
  output logic                 puf_rd_en,
  output logic [AW-1:0]        puf_addr,
  input  logic [WORD_W-1:0]    puf_word,
  output logic                 busy,
  output logic [CW-1:0]        bit_count,
  output logic [KEY_OUT_W-1:0] key,
  output logic                 key_valid,
  output logic                 short_flag
);
  logic              ram_we, s_vld, clr, reach;
  logic [AW-1:0]     ld_addr, rd_addr;
  logic [WORD_W-1:0] bm_word;
  logic [CW-1:0]     tgt, count, new_count;
  logic [WORD_W-1:0] take;
  logic [WORD_W*CW-1:0] pos;

  rba_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .CW(CW), .KW(KEY_W), .KO(KEY_OUT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_load(start_load), .ld_valid(ld_valid),
    .start_gen(start_gen), .target(target), .reach(reach),
    .new_count(new_count), .busy(busy), .ram_we(ram_we), .ld_addr(ld_addr),
    .rd_en(puf_rd_en), .rd_addr(rd_addr), .s_vld(s_vld), .clr(clr),
    .tgt(tgt), .count(count), .short_flag(short_flag), .key_valid(key_valid)
  );

  rba_bitmap_ram #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ld_addr), .wdata(ld_word),
    .re(puf_rd_en), .raddr(rd_addr), .rdata(bm_word)
  );

  rba_packer #(.W(WORD_W), .CW(CW)) u_pack (
    .valid(s_vld), .mask(bm_word), .count(count), .target(tgt),
    .take(take), .pos(pos), .new_count(new_count), .reach(reach)
  );

  rba_keyreg #(.W(WORD_W), .CW(CW), .KW(KEY_W), .KO(KEY_OUT_W)) u_key (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .pos(pos),
    .val(puf_word), .key_out(key)
  );

  assign puf_addr  = rd_addr;
  assign bit_count = count;
endmodule

// File: rtl/rba_chk.sv
module rba_chk #(
  parameter int WORD_W    = 4,
  parameter int KEY_W     = 512,
  parameter int KEY_OUT_W = 128,
  parameter int AW        = 10,
  parameter int CW        = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_gen,
  input logic                 busy,
  input logic                 puf_rd_en,
  input logic [AW-1:0]        puf_addr,
  input logic [CW-1:0]        bit_count,
  input logic [KEY_OUT_W-1:0] key,
  input logic                 key_valid,
  input logic                 short_flag
);
  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      ((bit_count >= $past(bit_count)) &&
       ((bit_count - $past(bit_count)) <= CW'(WORD_W))));

  // R10
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_count <= CW'(KEY_W));

  // R8
  kv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (!busy && (bit_count >= CW'(KEY_OUT_W))));

  // R7
  short_idle_chk: assert property (@(posedge clk) disable iff (rst)
    short_flag |-> !busy);

  // R4
  addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (puf_rd_en && $past(puf_rd_en)) |-> (puf_addr == $past(puf_addr) + 1'b1));

  // R4
  rd_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(puf_rd_en) |-> (puf_addr == '0));

  // R4
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    puf_rd_en |-> busy);

  // R3
  key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start_gen)) |-> $stable(key));
endmodule

bind reliable_bit_agg rba_chk #(
  .WORD_W(WORD_W), .KEY_W(KEY_W), .KEY_OUT_W(KEY_OUT_W), .AW(AW), .CW(CW)
) u_rba_chk (
  .clk(clk), .rst(rst), .start_gen(start_gen), .busy(busy),
  .puf_rd_en(puf_rd_en), .puf_addr(puf_addr), .bit_count(bit_count),
  .key(key), .key_valid(key_valid), .short_flag(short_flag)
);

// File: tb/reliable_bit_agg_bench.sv
module reliable_bit_agg_bench;
  localparam int N   = 1024;
  localparam int KW  = 512;
  localparam int KO  = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_load = 1'b0, ld_valid = 1'b0, start_gen = 1'b0;
  logic [3:0]    ld_word = '0;
  logic [9:0]    target = '0;
  logic          puf_rd_en, busy, key_valid, short_flag;
  logic [9:0]    puf_addr, bit_count;
  logic [3:0]    puf_word = '0;
  logic [KO-1:0] key;

  always #5 clk = ~clk;

  reliable_bit_agg u_reliable_bit_agg (
    .clk(clk), .rst(rst), .start_load(start_load), .ld_valid(ld_valid),
    .ld_word(ld_word), .start_gen(start_gen), .target(target),
    .puf_rd_en(puf_rd_en), .puf_addr(puf_addr), .puf_word(puf_word),
    .busy(busy), .bit_count(bit_count), .key(key), .key_valid(key_valid),
    .short_flag(short_flag)
  );

  logic [3:0] bm [N];
  logic [3:0] pv [N];

  // PUF array model: one-cycle read latency
  always @(posedge clk) if (puf_rd_en) puf_word <= pv[puf_addr];

  int tests = 0, fails = 0;
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic check(input string tag, input logic [KO-1:0] act, input logic [KO-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    int            cnt;
    bit            shrt;
    bit            kv;
    int            reads;
    logic [KO-1:0] key;
  } exp_t;

  exp_t q[$];
  bit   gen_pending = 0;
  bit   seen_busy = 0;
  int   reads = 0;

  function automatic exp_t model(input int tin);
    exp_t e;
    int t, ones, ra;
    t = (tin == 0) ? 1 : ((tin > KW) ? KW : tin);
    e.key = '0; e.cnt = 0; ones = 0; ra = -1;
    for (int a = 0; a < N; a++) begin
      for (int i = 0; i < 4; i++) begin
        if (bm[a][i]) begin
          if (e.cnt < t) begin
            if (e.cnt < KO) e.key[e.cnt] = pv[a][i];
            e.cnt++;
          end
          ones++;
        end
      end
      if (ra < 0 && ones >= t) ra = a;
    end
    e.shrt  = (ra < 0);
    e.reads = (ra < 0) ? N : ((ra + 2 > N) ? N : ra + 2);
    e.kv    = (e.cnt >= KO);
    return e;
  endfunction

  // Monitor: pops the expected result when a run finishes
  initial begin
    forever begin
      @(negedge clk);
      if (gen_pending) begin
        if (puf_rd_en) reads++;
        if (busy) seen_busy = 1;
        else if (seen_busy) begin
          exp_t e;
          e = q.pop_front();
          check("R5/R7 bit_count", KO'(bit_count), KO'(e.cnt));
          check("R7 short_flag", KO'(short_flag), KO'(e.shrt));
          check("R8 key_valid", KO'(key_valid), KO'(e.kv));
          check("R2/R3 key", key, e.key);
          check("R5 read count", KO'(reads), KO'(e.reads));
          gen_pending = 0;
          seen_busy = 0;
        end
      end
    end
  end

  task automatic load_bitmap();
    @(negedge clk) start_load = 1'b1;
    @(negedge clk) start_load = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i == 500) begin
        ld_valid = 1'b0; ld_word = 4'hF;   // gap: must not be written (R1)
        @(negedge clk);
      end
      ld_valid = 1'b1; ld_word = bm[i];
      if (i == N - 1) begin
        check("R1 busy during load", KO'(busy), KO'(1));
        check("R1 no read in load", KO'(puf_rd_en), KO'(0));
      end
      @(negedge clk);
    end
    ld_valid = 1'b0;
    check("R1 idle after last word", KO'(busy), KO'(0));
  endtask

  task automatic run_gen(input int tin, input bit poke);
    exp_t e;
    e = model(tin);
    q.push_back(e);
    reads = 0; seen_busy = 0;
    @(negedge clk) begin target = 10'(tin); start_gen = 1'b1; gen_pending = 1; end
    @(negedge clk) start_gen = 1'b0;
    check("R8 key_valid cleared on start", KO'(key_valid), KO'(0));
    check("R3 key cleared on start", key, '0);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_gen = 1'b1; start_load = 1'b1;     // R9: must be ignored
      @(negedge clk);
      start_gen = 1'b0; start_load = 1'b0;
    end
    while (gen_pending) @(negedge clk);
  endtask

  initial begin
    repeat (10000 * 15) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", KO'(busy), KO'(0));
    check("R11 count", KO'(bit_count), KO'(0));
    check("R11 key", key, '0);
    check("R11 flags", KO'({key_valid, short_flag, puf_rd_en}), KO'(0));

    // Pattern A: about half the bits reliable
    for (int a = 0; a < N; a++) begin bm[a] = rnd()[3:0]; pv[a] = rnd()[7:4]; end
    load_bitmap();
    run_gen(171, 1);          // R9 poke during run
    run_gen(0, 0);            // R6 zero -> one
    run_gen(1000, 0);         // R6 clamp to 512
    run_gen(128, 0);

    // R9: simultaneous starts while idle -> load wins
    @(negedge clk) begin start_gen = 1'b1; start_load = 1'b1; end
    @(negedge clk) begin start_gen = 1'b0; start_load = 1'b0; end
    check("R9 load wins, no read", KO'(puf_rd_en), KO'(0));
    for (int i = 0; i < N; i++) begin ld_valid = 1'b1; ld_word = bm[i]; @(negedge clk); end
    ld_valid = 1'b0;
    check("R9 load finished", KO'(busy), KO'(0));

    // Pattern B: every bit reliable
    for (int a = 0; a < N; a++) begin bm[a] = 4'hF; pv[a] = rnd()[11:8]; end
    load_bitmap();
    run_gen(6, 0);
    check("R5 bits past target dropped", KO'(key[7:6]), KO'(0));
    run_gen(128, 0);

    // Pattern C: set bits only at first and last address
    for (int a = 0; a < N; a++) begin bm[a] = 4'h0; pv[a] = 4'hF; end
    bm[0] = 4'b0010; bm[N-1] = 4'b1111; pv[N-1] = 4'b1010;
    load_bitmap();
    run_gen(5, 0);            // R7 target met exactly on last word
    run_gen(6, 0);            // R7 short by one
    run_gen(3, 0);            // R5 partial last word

    // Pattern D: sparse, short but above 128
    for (int a = 0; a < N; a++) begin
      logic [31:0] r;
      r = rnd();
      bm[a] = {r[3]&r[7]&r[11]&r[15], r[2]&r[6]&r[10]&r[14],
               r[1]&r[5]&r[9]&r[13],  r[0]&r[4]&r[8]&r[12]};
      pv[a] = r[19:16];
    end
    load_bitmap();
    run_gen(512, 0);          // R7/R8

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule